// File: doc/BRIEF.md
# Exception Entry Stack Frame Sequencer

This block carries out the bus work of a standard exception entry for a processor with a 16-bit data bus and a 32-bit address space. A one-cycle start pulse hands it a vector number, the status word in force, the current program counter and the supervisor stack pointer. The block then issues one word-wide access at a time over a request/acknowledge handshake. It stores a three-word frame on the stack, reads the new program counter from the vector table and refills the two-word instruction prefetch queue. After that it reports the results and pulses done for one cycle.

The stacked return address is the program counter minus 4, because two words have already been prefetched past the faulting instruction. The three stack writes are not issued in ascending order. The refill ends with an exact read, idle, read pattern. A start pulse that arrives while a sequence is in progress is dropped.

Top module: `exc_frame_seq`

## Requirements
- R1: After reset the block is idle: `busy_o`, `bus_req_o` and `done_o` are low. No request is raised while idle.
- R2: The status word is captured at start before any change. The word written to the stack is the unmodified incoming status. `new_status_o` equals that status with bit 13 (supervisor) set and bit 15 (trace) cleared, and every other bit unchanged.
- R3: The first access is a write (`bus_we_o`=1) of the captured status to address SP−6.
- R4: With return address RA = PC−4, the second access writes RA[15:0] to SP−2. The third access writes RA[31:16] to SP−4.
- R5: The fourth and fifth accesses are reads (`bus_we_o`=0) at vector×4 and then at vector×4+2. They return the high half and then the low half of the new PC.
- R6: The sixth access reads at the new PC. The next cycle has no request. The seventh access reads at new PC+2. The two read words appear on `prefetch0_o` and `prefetch1_o`.
- R7: `done_o` is high for exactly one cycle, the cycle after the seventh acknowledge, with no request that cycle. It comes with `new_pc_o` = new PC+4 and `new_sp_o` = SP−6, both modulo 2^32.
- R8: While `bus_req_o` is high and `bus_ack_i` is low, the request, address, direction and write data stay unchanged into the next cycle.
- R9: A start pulse while `busy_o` is high is ignored. The access sequence in progress continues unchanged.
- R10: Every address issued is even.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | One-cycle request to begin exception entry |
| vector_i | input | 8 | Exception vector number |
| status_i | input | 16 | Status word in force |
| pc_i | input | 32 | Current program counter (two words beyond the fault) |
| ssp_i | input | 32 | Supervisor stack pointer before the frame |
| bus_req_o | output | 1 | Access request |
| bus_we_o | output | 1 | 1 = write, 0 = read |
| bus_addr_o | output | 32 | Byte address of the word access |
| bus_wdata_o | output | 16 | Write data |
| bus_ack_i | input | 1 | Access acknowledge, sampled on the same edge as the request |
| bus_rdata_i | input | 16 | Read data, valid with acknowledge |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle completion pulse |
| new_pc_o | output | 32 | PC after the refill (new PC + 4) |
| new_sp_o | output | 32 | Stack pointer after the frame (SP − 6) |
| new_status_o | output | 16 | Status with supervisor set and trace cleared |
| prefetch0_o | output | 16 | First refilled prefetch word |
| prefetch1_o | output | 16 | Second refilled prefetch word |

## Verification
The assertions rely on two things about the inputs. Acknowledge is only raised in a cycle where a request is visible. Read data is only taken with that acknowledge. The bench drives acknowledge solely from a request it has just observed, holding it off for zero to three cycles chosen by a generator. It pulses start only while the block is idle, except in runs that deliberately fire a second start in mid-sequence to exercise the drop rule. The stack pointer, PC and vector values include wrap-around and end-of-table cases, so that address arithmetic is tested at its limits.

// File: rtl/exc_frame_pkg.sv
package exc_frame_pkg;
    typedef enum logic [3:0] {
        ST_IDLE,
        ST_PUSH_SR,
        ST_PUSH_RA_LO,
        ST_PUSH_RA_HI,
        ST_VEC_HI,
        ST_VEC_LO,
        ST_PF_A,
        ST_GAP,
        ST_PF_B,
        ST_FINISH
    } step_e;
endpackage

// File: rtl/exc_step_next.sv
module exc_step_next
    import exc_frame_pkg::*;
(
    input  step_e step_q,
    input  logic  start,
    input  logic  ack,
    output step_e step_d
);
    always_comb begin
        step_d = step_q;
        unique case (step_q)
            ST_IDLE:       if (start) step_d = ST_PUSH_SR;
            ST_PUSH_SR:    if (ack)   step_d = ST_PUSH_RA_LO;
            ST_PUSH_RA_LO: if (ack)   step_d = ST_PUSH_RA_HI;
            ST_PUSH_RA_HI: if (ack)   step_d = ST_VEC_HI;
            ST_VEC_HI:     if (ack)   step_d = ST_VEC_LO;
            ST_VEC_LO:     if (ack)   step_d = ST_PF_A;
            ST_PF_A:       if (ack)   step_d = ST_GAP;
            ST_GAP:                   step_d = ST_PF_B;
            ST_PF_B:       if (ack)   step_d = ST_FINISH;
            ST_FINISH:                step_d = ST_IDLE;
            default:                  step_d = ST_IDLE;
        endcase
    end
endmodule

// File: rtl/exc_bus_map.sv
module exc_bus_map
    import exc_frame_pkg::*;
#(
    parameter int AW = 32,
    parameter int DW = 16,
    parameter int VW = 8
) (
    input  step_e          step_q,
    input  logic [AW-1:0]  ssp,
    input  logic [AW-1:0]  ret,
    input  logic [DW-1:0]  sr,
    input  logic [VW-1:0]  vec,
    input  logic [AW-1:0]  vpc,
    output logic           req,
    output logic           we,
    output logic [AW-1:0]  addr,
    output logic [DW-1:0]  wdata
);
    localparam int WORD_B    = DW / 8;
    localparam int FRAME_B   = 3 * WORD_B;
    localparam int VEC_SHIFT = $clog2(2 * WORD_B);

    logic [AW-1:0] vec_base;
    assign vec_base = {{(AW-VW-VEC_SHIFT){1'b0}}, vec, {VEC_SHIFT{1'b0}}};

    always_comb begin
        req   = 1'b1;
        we    = 1'b0;
        addr  = '0;
        wdata = '0;
        unique case (step_q)
            ST_PUSH_SR: begin
                we = 1'b1; addr = ssp - AW'(FRAME_B); wdata = sr;
            end
            ST_PUSH_RA_LO: begin
                we = 1'b1; addr = ssp - AW'(WORD_B); wdata = ret[DW-1:0];
            end
            ST_PUSH_RA_HI: begin
                we = 1'b1; addr = ssp - AW'(2 * WORD_B); wdata = ret[AW-1 -: DW];
            end
            ST_VEC_HI: addr = vec_base;
            ST_VEC_LO: addr = vec_base + AW'(WORD_B);
            ST_PF_A:   addr = vpc;
            ST_PF_B:   addr = vpc + AW'(WORD_B);
            default:   req = 1'b0;
        endcase
    end
endmodule

// File: rtl/exc_frame_seq.sv
module exc_frame_seq
    import exc_frame_pkg::*;
#(
    parameter int AW     = 32,
    parameter int DW     = 16,
    parameter int VW     = 8,
    parameter int S_BIT  = 13,
    parameter int T_BIT  = 15
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic [VW-1:0] vector_i,
    input  logic [DW-1:0] status_i,
    input  logic [AW-1:0] pc_i,
    input  logic [AW-1:0] ssp_i,
    output logic          bus_req_o,
    output logic          bus_we_o,
    output logic [AW-1:0] bus_addr_o,
    output logic [DW-1:0] bus_wdata_o,
    input  logic          bus_ack_i,
    input  logic [DW-1:0] bus_rdata_i,
    output logic          busy_o,
    output logic          done_o,
    output logic [AW-1:0] new_pc_o,
    output logic [AW-1:0] new_sp_o,
    output logic [DW-1:0] new_status_o,
    output logic [DW-1:0] prefetch0_o,
    output logic [DW-1:0] prefetch1_o
);
    localparam int WORD_B   = DW / 8;
    localparam int FRAME_B  = 3 * WORD_B;
    localparam int QUEUE_B  = 2 * WORD_B;

    typedef struct packed {
        step_e         step;
        logic [DW-1:0] sr;
        logic [AW-1:0] ret;
        logic [AW-1:0] ssp;
        logic [VW-1:0] vec;
        logic [AW-1:0] vpc;
        logic [DW-1:0] pf0;
        logic [DW-1:0] pf1;
    } regs_t;

    regs_t r_q, r_d;
    step_e step_nx;
    logic  acc;

    exc_step_next u_next (
        .step_q (r_q.step),
        .start  (start_i),
        .ack    (acc),
        .step_d (step_nx)
    );

    exc_bus_map #(.AW(AW), .DW(DW), .VW(VW)) u_map (
        .step_q (r_q.step),
        .ssp    (r_q.ssp),
        .ret    (r_q.ret),
        .sr     (r_q.sr),
        .vec    (r_q.vec),
        .vpc    (r_q.vpc),
        .req    (bus_req_o),
        .we     (bus_we_o),
        .addr   (bus_addr_o),
        .wdata  (bus_wdata_o)
    );

    assign acc = bus_req_o && bus_ack_i;

    always_comb begin
        r_d      = r_q;
        r_d.step = step_nx;
        if (r_q.step == ST_IDLE && start_i) begin
            r_d.sr  = status_i;
            r_d.ret = pc_i - AW'(QUEUE_B);
            r_d.ssp = ssp_i;
            r_d.vec = vector_i;
        end
        if (acc) begin
            unique case (r_q.step)
                ST_VEC_HI: r_d.vpc[AW-1 -: DW] = bus_rdata_i;
                ST_VEC_LO: r_d.vpc[DW-1:0]     = bus_rdata_i;
                ST_PF_A:   r_d.pf0             = bus_rdata_i;
                ST_PF_B:   r_d.pf1             = bus_rdata_i;
                default:   ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q      <= '0;
            r_q.step <= ST_IDLE;
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        new_status_o        = r_q.sr;
        new_status_o[S_BIT] = 1'b1;
        new_status_o[T_BIT] = 1'b0;
    end

    assign busy_o      = (r_q.step != ST_IDLE);
    assign done_o      = (r_q.step == ST_FINISH);
    assign new_pc_o    = r_q.vpc + AW'(QUEUE_B);
    assign new_sp_o    = r_q.ssp - AW'(FRAME_B);
    assign prefetch0_o = r_q.pf0;
    assign prefetch1_o = r_q.pf1;
endmodule

// File: rtl/exc_frame_seq_chk.sv
module exc_frame_seq_chk #(
    parameter int AW    = 32,
    parameter int DW    = 16,
    parameter int S_BIT = 13,
    parameter int T_BIT = 15
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start_i,
    input logic          busy_o,
    input logic          done_o,
    input logic          bus_req_o,
    input logic          bus_we_o,
    input logic [AW-1:0] bus_addr_o,
    input logic [DW-1:0] bus_wdata_o,
    input logic          bus_ack_i,
    input logic [DW-1:0] new_status_o
);
    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> !bus_req_o);

    assert_status_bits_R2: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (new_status_o[S_BIT] && !new_status_o[T_BIT]));

    assert_done_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    assert_done_no_req_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !bus_req_o);

    assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req_o && !bus_ack_i) |=> (bus_req_o && $stable(bus_addr_o)
            && $stable(bus_we_o) && $stable(bus_wdata_o)));

    assert_stay_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !done_o && start_i) |=> busy_o);

    assert_even_addr_R10: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req_o |-> !bus_addr_o[0]);
endmodule

bind exc_frame_seq exc_frame_seq_chk #(
    .AW(AW), .DW(DW), .S_BIT(S_BIT), .T_BIT(T_BIT)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_i      (start_i),
    .busy_o       (busy_o),
    .done_o       (done_o),
    .bus_req_o    (bus_req_o),
    .bus_we_o     (bus_we_o),
    .bus_addr_o   (bus_addr_o),
    .bus_wdata_o  (bus_wdata_o),
    .bus_ack_i    (bus_ack_i),
    .new_status_o (new_status_o)
);

// File: tb/tb_exc_frame_seq.sv
module tb_exc_frame_seq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [7:0]  vector_i = '0;
    logic [15:0] status_i = '0;
    logic [31:0] pc_i = '0;
    logic [31:0] ssp_i = '0;
    logic        bus_req_o, bus_we_o;
    logic [31:0] bus_addr_o;
    logic [15:0] bus_wdata_o;
    logic        bus_ack_i = 1'b0;
    logic [15:0] bus_rdata_i = '0;
    logic        busy_o, done_o;
    logic [31:0] new_pc_o, new_sp_o;
    logic [15:0] new_status_o, prefetch0_o, prefetch1_o;

    always #5 clk = ~clk;

    exc_frame_seq dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .vector_i(vector_i),
        .status_i(status_i), .pc_i(pc_i), .ssp_i(ssp_i),
        .bus_req_o(bus_req_o), .bus_we_o(bus_we_o), .bus_addr_o(bus_addr_o),
        .bus_wdata_o(bus_wdata_o), .bus_ack_i(bus_ack_i), .bus_rdata_i(bus_rdata_i),
        .busy_o(busy_o), .done_o(done_o), .new_pc_o(new_pc_o), .new_sp_o(new_sp_o),
        .new_status_o(new_status_o), .prefetch0_o(prefetch0_o), .prefetch1_o(prefetch1_o)
    );

    typedef struct packed {
        logic [31:0] a;
        logic        w;
        logic [15:0] d;
    } acc_t;

    acc_t        q[$];
    int          checks = 0, fails = 0, idx = 0, wait_n = 0;
    logic [31:0] seed = 32'h1234_5678;
    logic        gap_exp = 0, done_exp = 0, done_after = 0, done_seen = 0;
    logic [31:0] exp_pc, exp_sp;
    logic [15:0] exp_st, exp_p0, exp_p1;
    int          cyc = 0;
    logic        ended = 0;

    task automatic chk(input logic ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic string tag_of(input int i);
        if (i == 0) return "R3";
        if (i < 3)  return "R4";
        if (i < 5)  return "R5";
        return "R6";
    endfunction

    function automatic int next_wait();
        seed = seed * 32'd1103515245 + 32'd12345;
        return int'(seed[17:16]);
    endfunction

    // Reference model: per-cycle bus responder and expectation checker
    always @(negedge clk) begin
        if (rst_n) begin
            bus_ack_i = 1'b0;
            if (done_after) begin
                chk(!done_o, "R7", "done pulse width", {31'b0, done_o}, 32'd0);
                done_after = 0;
            end
            if (done_exp) begin
                chk(done_o, "R7", "done", {31'b0, done_o}, 32'd1);
                chk(!bus_req_o, "R7", "req at done", {31'b0, bus_req_o}, 32'd0);
                chk(new_pc_o == exp_pc, "R7", "new pc", new_pc_o, exp_pc);
                chk(new_sp_o == exp_sp, "R7", "new sp", new_sp_o, exp_sp);
                chk(new_status_o == exp_st, "R2", "new status", {16'b0, new_status_o}, {16'b0, exp_st});
                chk(prefetch0_o == exp_p0, "R6", "prefetch0", {16'b0, prefetch0_o}, {16'b0, exp_p0});
                chk(prefetch1_o == exp_p1, "R6", "prefetch1", {16'b0, prefetch1_o}, {16'b0, exp_p1});
                done_exp = 0; done_after = 1; done_seen = 1;
            end else if (gap_exp) begin
                chk(!bus_req_o, "R6", "idle cycle between prefetches", {31'b0, bus_req_o}, 32'd0);
                gap_exp = 0;
            end else if (bus_req_o) begin
                if (q.size() == 0) begin
                    chk(1'b0, "R9", "request with nothing expected", bus_addr_o, 32'd0);
                end else begin
                    chk(bus_addr_o == q[0].a, tag_of(idx), "address", bus_addr_o, q[0].a);
                    chk(bus_we_o == q[0].w, tag_of(idx), "direction", {31'b0, bus_we_o}, {31'b0, q[0].w});
                    if (q[0].w)
                        chk(bus_wdata_o == q[0].d, (idx == 0) ? "R2" : tag_of(idx), "write data",
                            {16'b0, bus_wdata_o}, {16'b0, q[0].d});
                    if (wait_n == 0) begin
                        bus_ack_i = 1'b1;
                        bus_rdata_i = q[0].w ? 16'hDEAD : q[0].d;
                        void'(q.pop_front());
                        if (idx == 5) gap_exp = 1;
                        if (idx == 6) done_exp = 1;
                        idx++;
                        wait_n = next_wait();
                    end else begin
                        wait_n--;
                    end
                end
            end else if (done_o) begin
                chk(1'b0, "R7", "unexpected done", 32'd1, 32'd0);
            end
        end
    end

    task automatic run_case(input logic [7:0] vec, input logic [15:0] sr,
                            input logic [31:0] pc, input logic [31:0] ssp,
                            input logic [15:0] vh, input logic [15:0] vl,
                            input logic [15:0] p0, input logic [15:0] p1,
                            input logic poke);
        logic [31:0] ra, npc, vb;
        int t;
        ra  = pc - 32'd4;
        npc = {vh, vl};
        vb  = {22'b0, vec, 2'b00};
        @(negedge clk);
        idx = 0; done_seen = 0;
        wait_n = next_wait();
        q.push_back('{ssp - 32'd6, 1'b1, sr});
        q.push_back('{ssp - 32'd2, 1'b1, ra[15:0]});
        q.push_back('{ssp - 32'd4, 1'b1, ra[31:16]});
        q.push_back('{vb, 1'b0, vh});
        q.push_back('{vb + 32'd2, 1'b0, vl});
        q.push_back('{npc, 1'b0, p0});
        q.push_back('{npc + 32'd2, 1'b0, p1});
        exp_pc = npc + 32'd4;
        exp_sp = ssp - 32'd6;
        exp_st = (sr | 16'h2000) & ~16'h8000;
        exp_p0 = p0; exp_p1 = p1;
        vector_i = vec; status_i = sr; pc_i = pc; ssp_i = ssp;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        if (poke) begin
            repeat (2) @(negedge clk);
            // R9: second start mid-sequence with different operands
            vector_i = ~vec; status_i = ~sr; pc_i = pc + 32'h100; ssp_i = ssp - 32'h40;
            start_i = 1'b1;
            @(negedge clk);
            start_i = 1'b0;
        end
        t = 0;
        while (!done_seen && t < 300) begin
            @(negedge clk);
            t++;
        end
        chk(done_seen, "R7", "sequence completed", {31'b0, done_seen}, 32'd1);
        chk(q.size() == 0, "R9", "all expected accesses issued", q.size(), 32'd0);
        q.delete();
        repeat (3) @(negedge clk);
        chk(!busy_o, "R1", "idle after done", {31'b0, busy_o}, 32'd0);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000 && !ended) begin
            ended = 1;
            fails++;
            $display("FAIL watchdog: actual %0d cycles expected under 100000", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk(!busy_o, "R1", "busy after reset", {31'b0, busy_o}, 32'd0);
        chk(!bus_req_o, "R1", "req after reset", {31'b0, bus_req_o}, 32'd0);
        chk(!done_o, "R1", "done after reset", {31'b0, done_o}, 32'd0);

        run_case(8'd6,   16'h2700, 32'h0000_1004, 32'h0000_8000, 16'h0001, 16'h2340, 16'h4E71, 16'h4E75, 1'b0);
        run_case(8'd0,   16'h8015, 32'h00FF_0010, 32'h0010_0000, 16'hABCD, 16'hEF00, 16'h1111, 16'h2222, 1'b0);
        run_case(8'd255, 16'hFFFF, 32'h0000_0002, 32'h0000_0004, 16'hFFFF, 16'hFFFE, 16'h3333, 16'h4444, 1'b0);
        run_case(8'd7,   16'h0000, 32'h1234_5678, 32'hFFFF_FFFE, 16'h0000, 16'h0000, 16'h5555, 16'hAAAA, 1'b1);
        run_case(8'd32,  16'hA51F, 32'h8000_0000, 32'h7FFF_FFF0, 16'h8000, 16'h0400, 16'h0F0F, 16'hF0F0, 1'b1);
        for (int i = 0; i < 6; i++)
            run_case(8'(i * 37 + 3), 16'(i * 16'h1357), 32'h0004_0000 + 32'(i * 64),
                     32'h0002_0000 - 32'(i * 256), 16'(i + 1), 16'(i * 4 + 16'h100),
                     16'(i + 16'h7000), 16'(i + 16'h7100), i[0]);

        if (!ended) begin
            ended = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule